// File: doc/BRIEF.md
# Receive Byte Queue with Break Marking

This block holds received bytes between a serial deserializer and a register read port. Bytes enter from the deserializer through a valid/ready push port. The block raises ready only while the receiver is enabled and the queue has room. The oldest stored byte is always visible on the read-data output. A read strobe removes that byte, and the next one appears one cycle later.

A line-break event from the receiver is stored as a zero byte and latches a sticky break flag, which software clears with a one-cycle clear strobe. A break stays visible even when the queue is already full: the newest stored byte is replaced by the zero, and the occupancy stays the same. A receiver-reset flush empties the queue in one cycle. Two status levels tell the register side whether any data is waiting and whether the queue is full.

Top module: `rxq_break_fifo`

## Requirements
- R1: The queue holds DEPTH (default 4) bytes. `full_flag` is 1 exactly when DEPTH bytes are stored. `push_ready` is 1 exactly when `rx_enable` is 1 and `full_flag` is 0.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte combinationally, and after a cycle with `pop` high it shows the next byte.
- R3: `rdy_flag` is 1 whenever at least one byte is stored. It rises after any accepted push or break, and it falls after a pop that removes the last byte.
- R4: A pop from a full queue clears `full_flag` in the following cycle.
- R5: A byte on `push_data` is stored only in a cycle where `push_valid` and `push_ready` are both 1. With `rx_enable` low, or with the queue full, `push_valid` has no effect on the stored data or on the flags.
- R6: A cycle with `break_event` high stores the byte 0x00 and ignores `push_data` in that cycle. This happens regardless of `rx_enable`. If the queue is full and no pop occurs in that cycle, the zero replaces the newest entry and the queue stays full.
- R7: A pop on an empty queue leaves `rd_data` at 0x00 and leaves `rdy_flag` and `full_flag` unchanged.
- R8: A cycle with `flush` high empties the queue and clears `rdy_flag` and `full_flag`. It overrides any push, break or pop in the same cycle, and it leaves `brk_flag` unchanged.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged and keep the arrival order.
- R10: `brk_flag` is set by `break_event` and stays set until a cycle with `brk_clr` high. If `break_event` and `brk_clr` are high in the same cycle, the flag is set.
- R11: After reset the queue is empty: `rdy_flag`, `full_flag` and `brk_flag` are 0, and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enabled level |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | DATA_W | Offered byte |
| push_ready | output | 1 | Queue accepts a byte this cycle |
| break_event | input | 1 | Line break detected (one cycle per event) |
| pop | input | 1 | Register read removes the oldest byte |
| rd_data | output | DATA_W | Oldest stored byte, 0 when empty |
| flush | input | 1 | Receiver reset: empty the queue |
| brk_clr | input | 1 | Clear the sticky break flag |
| rdy_flag | output | 1 | At least one byte stored |
| full_flag | output | 1 | Queue holds DEPTH bytes |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The queue is filled through every occupancy and then drained. This shows whether the order is kept and whether the flags switch at the right counts. A push offered while the queue is full is mixed in with a push offered while the receiver is disabled, so acceptance gated by ready can be told apart from acceptance gated by enable. A break on a partly filled queue and a break on a full queue are then drained one byte at a time. The drained bytes separate a normal append from an in-place overwrite of the newest entry. Collisions in a single cycle are tried on their own: flush against push and pop, break against a clear and against a byte offered in the same cycle, and push against pop. Each collision has a unique expected result.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Action the queue takes in one cycle.
    typedef enum logic [2:0] {
        RXQ_IDLE      = 3'd0,
        RXQ_PUSH      = 3'd1,
        RXQ_POP       = 3'd2,
        RXQ_PUSH_POP  = 3'd3,
        RXQ_OVERWRITE = 3'd4,
        RXQ_FLUSH     = 3'd5
    } rxq_op_e;

endpackage

// File: rtl/rxq_arbiter.sv
module rxq_arbiter
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rx_enable,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              break_event,
    input  logic              pop,
    input  logic              flush,
    input  logic              empty,
    input  logic              full,
    output logic              push_ready,
    output rxq_op_e           op,
    output logic [DATA_W-1:0] wr_data
);

    logic accept_byte;
    logic insert;
    logic take;

    always_comb begin
        push_ready  = rx_enable && !full;
        accept_byte = push_valid && push_ready;
        insert      = accept_byte || break_event;
        take        = pop && !empty;
        // A break stores a zero byte in place of any offered data.
        wr_data     = break_event ? '0 : push_data;

        if (flush) begin
            op = RXQ_FLUSH;
        end else if (insert && full && !take) begin
            op = RXQ_OVERWRITE;
        end else if (insert && take) begin
            op = RXQ_PUSH_POP;
        end else if (insert) begin
            op = RXQ_PUSH;
        end else if (take) begin
            op = RXQ_POP;
        end else begin
            op = RXQ_IDLE;
        end
    end

    // Only a break can insert into a full queue that is not being drained.
    always_comb begin
        if (op == RXQ_OVERWRITE) begin
            assert_overwrite_is_break_R6: assert (break_event);
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  rxq_op_e                       op,
    output logic                          wr_en,
    output logic [$clog2(DEPTH)-1:0]      wr_idx,
    output logic [$clog2(DEPTH)-1:0]      rd_idx,
    output logic                          empty,
    output logic                          full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_PTR : p - PTR_W'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = st_q.wr;
        unique case (op)
            RXQ_PUSH: begin
                wr_en    = 1'b1;
                st_d.wr  = ptr_inc(st_q.wr);
                st_d.cnt = st_q.cnt + ONE_CNT;
            end
            RXQ_POP: begin
                st_d.rd  = ptr_inc(st_q.rd);
                st_d.cnt = st_q.cnt - ONE_CNT;
            end
            RXQ_PUSH_POP: begin
                wr_en   = 1'b1;
                st_d.wr = ptr_inc(st_q.wr);
                st_d.rd = ptr_inc(st_q.rd);
            end
            RXQ_OVERWRITE: begin
                wr_en  = 1'b1;
                wr_idx = ptr_dec(st_q.wr);
            end
            RXQ_FLUSH: begin
                st_d = '0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.rd;
    assign empty  = (st_q.cnt == '0);
    assign full   = (st_q.cnt == FULL_CNT);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op == RXQ_FLUSH |=> empty);

    assert_overwrite_stays_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == RXQ_OVERWRITE |=> full && $stable(st_q.rd));

    assert_pushpop_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op == RXQ_PUSH_POP |=> $stable(st_q.cnt));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty && op != RXQ_PUSH && op != RXQ_PUSH_POP |=> empty);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    input  logic                     empty,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign rd_data = empty ? '0 : mem_q[rd_idx];

    assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> rd_data == '0);

endmodule

// File: rtl/rxq_brk_flag.sv
module rxq_brk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic break_event,
    input  logic brk_clr,
    output logic brk_flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (brk_clr) begin
            flag_d = 1'b0;
        end
        if (break_event) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign brk_flag = flag_q;

    assert_break_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        break_event |=> brk_flag);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag && !brk_clr |=> brk_flag);

endmodule

// File: rtl/rxq_break_fifo.sv
module rxq_break_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              break_event,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush,
    input  logic              brk_clr,
    output logic              rdy_flag,
    output logic              full_flag,
    output logic              brk_flag
);

    localparam int PTR_W = $clog2(DEPTH);

    rxq_op_e           op;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;
    logic              empty;
    logic              full;

    rxq_arbiter #(.DATA_W(DATA_W)) i_arbiter (
        .rx_enable   (rx_enable),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .break_event (break_event),
        .pop         (pop),
        .flush       (flush),
        .empty       (empty),
        .full        (full),
        .push_ready  (push_ready),
        .op          (op),
        .wr_data     (wr_data)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .empty  (empty),
        .full   (full)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .empty   (empty),
        .rd_data (rd_data)
    );

    rxq_brk_flag i_brk (
        .clk         (clk),
        .rst_n       (rst_n),
        .break_event (break_event),
        .brk_clr     (brk_clr),
        .brk_flag    (brk_flag)
    );

    assign rdy_flag  = !empty;
    assign full_flag = full;

    assert_ready_only_with_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push_ready |-> !full_flag && rx_enable);

    assert_push_sets_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && push_ready && !flush |=> rdy_flag);

    assert_pop_full_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag && pop && !break_event && !flush |=> !full_flag);

    assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable && !break_event && !pop && !flush |=> $stable(rdy_flag) && $stable(full_flag));

endmodule

// File: tb/test_rxq_break_fifo.sv
module test_rxq_break_fifo;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_enable = 1'b0;
    logic              push_valid = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              push_ready;
    logic              break_event = 1'b0;
    logic              pop = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              flush = 1'b0;
    logic              brk_clr = 1'b0;
    logic              rdy_flag;
    logic              full_flag;
    logic              brk_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rxq_break_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rxq_break_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_enable   (rx_enable),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .push_ready  (push_ready),
        .break_event (break_event),
        .pop         (pop),
        .rd_data     (rd_data),
        .flush       (flush),
        .brk_clr     (brk_clr),
        .rdy_flag    (rdy_flag),
        .full_flag   (full_flag),
        .brk_flag    (brk_flag)
    );

    typedef struct packed {
        logic       en;
        logic       pv;
        logic [7:0] pd;
        logic       pp;
        logic       bk;
        logic       cl;
        logic       fl;
        logic       x_rdy;
        logic       x_full;
        logic       x_brk;
        logic [7:0] x_head;
    } vec_t;

    localparam int NV = 22;
    // Inputs held for one cycle; expected outputs after that edge.
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1},
        '{1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1},
        '{1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1},
        '{1'b1, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA1},
        '{1'b1, 1'b1, 8'hE5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA1},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB2},
        '{1'b1, 1'b1, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hD4},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h66},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11},
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11},
        '{1'b1, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11},
        '{1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11},
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00},
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic pv, input logic [7:0] pd,
                         input logic pp, input logic bk, input logic cl, input logic fl);
        rx_enable   = en;
        push_valid  = pv;
        push_data   = pd;
        pop         = pp;
        break_event = bk;
        brk_clr     = cl;
        flush       = fl;
    endtask

    task automatic step(input logic en, input logic pv, input logic [7:0] pd,
                        input logic pp, input logic bk, input logic cl, input logic fl);
        drive(en, pv, pd, pp, bk, cl, fl);
        @(posedge clk);
        @(negedge clk);
        drive(en, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 rdy", 32'(rdy_flag), 0);
        chk("R11 full", 32'(full_flag), 0);
        chk("R11 brk", 32'(brk_flag), 0);
        chk("R11 data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            step(TBL[v].en, TBL[v].pv, TBL[v].pd, TBL[v].pp, TBL[v].bk, TBL[v].cl, TBL[v].fl);
            chk($sformatf("R3 table %0d rdy", v), 32'(rdy_flag), 32'(TBL[v].x_rdy));
            chk($sformatf("R1 table %0d full", v), 32'(full_flag), 32'(TBL[v].x_full));
            chk($sformatf("R10 table %0d brk", v), 32'(brk_flag), 32'(TBL[v].x_brk));
            chk($sformatf("R2 table %0d head", v), 32'(rd_data), 32'(TBL[v].x_head));
        end

        // R1: push_ready follows enable and room
        drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        #1 chk("R1 ready enabled empty", 32'(push_ready), 1);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        #1 chk("R1 ready disabled", 32'(push_ready), 0);
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b1, 8'(8'h40 + k), 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 ready full", 32'(push_ready), 0);
        chk("R1 full after fill", 32'(full_flag), 1);

        // R8: flush beats push and pop, break flag kept
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 break on full keeps full", 32'(full_flag), 1);
        step(1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R8 flush rdy", 32'(rdy_flag), 0);
        chk("R8 flush full", 32'(full_flag), 0);
        chk("R8 flush data", 32'(rd_data), 0);
        chk("R8 flush keeps brk", 32'(brk_flag), 1);

        // R10: break and clear together keep the flag
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 break+clr", 32'(brk_flag), 1);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 clr", 32'(brk_flag), 0);

        // R6: break ignores offered byte, stores one zero, even when disabled
        step(1'b0, 1'b1, 8'h9C, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 break rdy", 32'(rdy_flag), 1);
        chk("R6 break data zero", 32'(rd_data), 0);
        step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 single entry", 32'(rdy_flag), 0);

        // R2: head visible combinationally while pop is high, next one after edge
        step(1'b1, 1'b1, 8'h31, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h32, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        #1 chk("R2 head before pop edge", 32'(rd_data), 32'h31);
        @(posedge clk);
        @(negedge clk);
        drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 head after pop", 32'(rd_data), 32'h32);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule